// File: doc/BRIEF.md
# Serial Receiver with Line Error Detection

This block recovers asynchronous characters from a single serial input line. A 16x oversampling tick (one pulse per sixteenth of a bit, produced elsewhere) paces a framer that hunts for a start edge and confirms it at mid-bit. It then gathers 5 to 8 data bits LSB first, an optional ninth bit (parity or multi-drop address flag), and one stop bit. Each completed character goes into a receive queue together with its own status bits: parity error, framing error, break and address flag. A host drains the queue one entry per read strobe.

Break conditions are followed as line states. A break that starts partway through a character still ends up recognised. The start and the end of a break each produce a single-cycle event. In multi-drop operation the ninth bit marks address characters. The receiver can be left asleep so that it discards data characters until an address character wakes it. If the queue is full when a character completes, the queue keeps its contents and a sticky overrun flag is raised.

Top module: `serial_rx`

## Requirements
- R1: `cfg_len` selects the data length as 5 + `cfg_len` bits (0 gives 5, 3 gives 8). Bits arrive LSB first and are stored right-aligned in `rd_data`, with unused upper bits zero.
- R2: A low level seen at a tick is a candidate start bit. It is re-sampled 8 ticks later and dropped, storing nothing, if the line is high by then. Each following bit is sampled once per 16 ticks.
- R3: `cfg_par` encodes the parity mode: 0 none, 1 even, 2 odd, 3 ninth bit forced 0, 4 ninth bit forced 1. `rd_perr` is set when the received ninth bit disagrees with the mode.
- R4: A stop bit sampled low sets `rd_ferr` on that character's entry.
- R5: A character whose data bits, ninth bit (if present) and stop bit are all 0 is a break. Exactly one entry is stored for it, with data 0, `rd_brk`=1 and the other error bits 0. Nothing more is stored until the line has returned high.
- R6: `brk_evt` pulses for one cycle when a break is recognised and again when the line returns high after it.
- R7: If the line drops low and stays low partway through a character, that character is stored with `rd_ferr`=1 and the low line that follows is then stored as one break entry.
- R8: The queue holds DEPTH (16) entries in arrival order. `rd_en` while `level` is nonzero pops one entry, presented with `rd_vld`=1 in the next cycle. `rd_en` while empty gives no `rd_vld`. `level` counts the stored entries.
- R9: A character that completes while the queue is full is discarded, the stored entries are kept, and `ovr_flag` is set and stays set until `ovr_clr` is pulsed.
- R10: With `cfg_mdrop`=1 the ninth bit is always present and is returned as `rd_addr` (1 = address). It never sets `rd_perr`, whatever `cfg_par` is.
- R11: With `cfg_mdrop`=1 and `cfg_autowake`=1, a sleeping receiver discards characters whose flag is 0. A character with flag 1 wakes it and is itself stored. `sleep_req` puts it back to sleep, and it is asleep after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 2 | Data length minus 5 |
| cfg_par | input | 3 | Parity mode (0 none, 1 even, 2 odd, 3 force 0, 4 force 1) |
| cfg_mdrop | input | 1 | Multi-drop mode, ninth bit is address flag |
| cfg_autowake | input | 1 | Discard data characters while asleep |
| sleep_req | input | 1 | Pulse: return receiver to sleep |
| rd_en | input | 1 | Pop one entry from the queue |
| ovr_clr | input | 1 | Pulse: clear the overrun flag |
| rd_vld | output | 1 | Popped entry valid this cycle |
| rd_data | output | 8 | Popped character, right-aligned |
| rd_perr | output | 1 | Popped entry parity error |
| rd_ferr | output | 1 | Popped entry framing error |
| rd_brk | output | 1 | Popped entry is a break |
| rd_addr | output | 1 | Popped entry address flag |
| level | output | $clog2(DEPTH)+1 | Number of stored entries |
| ovr_flag | output | 1 | Sticky overrun indication |
| brk_evt | output | 1 | Pulse at break start and break end |

## Verification
The bench builds the block with its defaults: 16 ticks per bit, a 16-entry queue and a two-stage input synchroniser. The tick arrives every second clock, so one bit lasts 32 clocks. With the full 16-entry depth, seventeen back-to-back characters are enough to reach the overrun boundary and check that the oldest entry survives. The 8-tick start confirmation point lets a 3-tick glitch exercise false-start rejection. All four data lengths can be reached, and so can every parity encoding. Multi-drop sleep and wake can be reached through the ninth-bit slot.

// File: rtl/rx_pkg.sv
package rx_pkg;

  localparam logic [2:0] PM_NONE = 3'd0;
  localparam logic [2:0] PM_EVEN = 3'd1;
  localparam logic [2:0] PM_ODD  = 3'd2;
  localparam logic [2:0] PM_ZERO = 3'd3;
  localparam logic [2:0] PM_ONE  = 3'd4;

  typedef struct packed {
    logic       addr;
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rx_ent_t;

  localparam int ENT_W = $bits(rx_ent_t);

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[STAGES-2:0], din};
  end

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rx,
  input  logic [1:0] cfg_len,
  input  logic [2:0] cfg_par,
  input  logic       cfg_mdrop,
  output logic       done,
  output rx_ent_t    ent,
  output logic       brk_evt
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_NINTH, S_STOP, S_BRKW} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [2:0]   bidx;
  logic [7:0]   data_q;
  logic         nb_q;
  logic         has9, perr_c, is_brk, last_bit, par_mode;

  assign par_mode = (cfg_par == PM_EVEN) || (cfg_par == PM_ODD) ||
                    (cfg_par == PM_ZERO) || (cfg_par == PM_ONE);
  assign has9     = cfg_mdrop || par_mode;
  assign last_bit = (bidx == (3'(cfg_len) + 3'd4));
  assign is_brk   = (data_q == 8'h00) && !(has9 && nb_q) && !rx;

  always_comb begin
    perr_c = 1'b0;
    if (!cfg_mdrop) begin
      case (cfg_par)
        PM_EVEN: perr_c = (^data_q) ^ nb_q;
        PM_ODD:  perr_c = ~((^data_q) ^ nb_q);
        PM_ZERO: perr_c = nb_q;
        PM_ONE:  perr_c = ~nb_q;
        default: perr_c = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      data_q  <= '0;
      nb_q    <= 1'b0;
      done    <= 1'b0;
      ent     <= '0;
      brk_evt <= 1'b0;
    end else begin
      done    <= 1'b0;
      brk_evt <= 1'b0;
      case (st)
        S_IDLE: if (tick && !rx) begin
          st  <= S_START;
          cnt <= '0;
        end
        S_START: if (tick) begin
          if (cnt == MID) begin
            cnt    <= '0;
            bidx   <= '0;
            data_q <= '0;
            nb_q   <= 1'b0;
            st     <= rx ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: if (tick) begin
          if (cnt == LAST) begin
            cnt          <= '0;
            data_q[bidx] <= rx;
            if (last_bit) st <= has9 ? S_NINTH : S_STOP;
            else          bidx <= bidx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        S_NINTH: if (tick) begin
          if (cnt == LAST) begin
            cnt  <= '0;
            nb_q <= rx;
            st   <= S_STOP;
          end else cnt <= cnt + 1'b1;
        end
        S_STOP: if (tick) begin
          if (cnt == LAST) begin
            cnt  <= '0;
            done <= 1'b1;
            if (is_brk) begin
              ent     <= '{addr: 1'b0, brk: 1'b1, ferr: 1'b0, perr: 1'b0, data: 8'h00};
              brk_evt <= 1'b1;
              st      <= S_BRKW;
            end else begin
              ent <= '{addr: cfg_mdrop & nb_q, brk: 1'b0, ferr: ~rx,
                       perr: has9 & perr_c, data: data_q};
              st  <= S_IDLE;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_BRKW: if (rx) begin
          brk_evt <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   push,
  input  logic [W-1:0]           wdata,
  input  logic                   pop,
  output logic [W-1:0]           rdata,
  output logic                   rvld,
  output logic [$clog2(DEPTH):0] level,
  output logic                   full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (level == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && (level != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (do_pop) rdata <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
      rvld  <= 1'b0;
    end else begin
      rvld <= do_pop;
      if (do_push) wp <= (wp == TOP) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == TOP) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import rx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 16,
  parameter int SYNC  = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick16,
  input  logic                   rxd,
  input  logic [1:0]             cfg_len,
  input  logic [2:0]             cfg_par,
  input  logic                   cfg_mdrop,
  input  logic                   cfg_autowake,
  input  logic                   sleep_req,
  input  logic                   rd_en,
  input  logic                   ovr_clr,
  output logic                   rd_vld,
  output logic [7:0]             rd_data,
  output logic                   rd_perr,
  output logic                   rd_ferr,
  output logic                   rd_brk,
  output logic                   rd_addr,
  output logic [$clog2(DEPTH):0] level,
  output logic                   ovr_flag,
  output logic                   brk_evt
);
  logic    rx_s, done, full, keep, asleep, gate;
  rx_ent_t ent, rent;
  logic [ENT_W-1:0] rword;

  rx_sync #(.STAGES(SYNC)) u_sync (.clk(clk), .rst(rst), .din(rxd), .dout(rx_s));

  rx_frame #(.OSR(OSR)) u_frame (
    .clk(clk), .rst(rst), .tick(tick16), .rx(rx_s),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_mdrop(cfg_mdrop),
    .done(done), .ent(ent), .brk_evt(brk_evt)
  );

  assign gate = cfg_mdrop && cfg_autowake;
  assign keep = !(gate && asleep && !ent.addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      asleep   <= 1'b1;
      ovr_flag <= 1'b0;
    end else begin
      if (sleep_req)                     asleep <= 1'b1;
      else if (done && gate && ent.addr) asleep <= 1'b0;
      if (done && keep && full) ovr_flag <= 1'b1;
      else if (ovr_clr)         ovr_flag <= 1'b0;
    end
  end

  rx_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(done && keep), .wdata(ent),
    .pop(rd_en), .rdata(rword), .rvld(rd_vld), .level(level), .full(full)
  );

  assign rent    = rx_ent_t'(rword);
  assign rd_data = rent.data;
  assign rd_perr = rent.perr;
  assign rd_ferr = rent.ferr;
  assign rd_brk  = rent.brk;
  assign rd_addr = rent.addr;
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   rd_en,
  input logic                   rd_vld,
  input logic                   ovr_clr,
  input logic                   ovr_flag,
  input logic [$clog2(DEPTH):0] level
);
  localparam int LW = $clog2(DEPTH) + 1;

  a_r8_level_bound: assert property (@(posedge clk) disable iff (rst)
    int'(level) <= DEPTH);

  a_r8_vld_after_rd: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> $past(rd_en));

  a_r8_empty_no_vld: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |=> !rd_vld);

  a_r8_level_step: assert property (@(posedge clk) disable iff (rst)
    (level == $past(level)) || (level == $past(level) + LW'(1)) ||
    (level + LW'(1) == $past(level)));

  a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovr_flag && !ovr_clr) |=> ovr_flag);

  a_r9_full_holds: assert property (@(posedge clk) disable iff (rst)
    (int'(level) == DEPTH && !rd_en) |=> (int'(level) == DEPTH));
endmodule

bind serial_rx serial_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_vld(rd_vld),
  .ovr_clr(ovr_clr), .ovr_flag(ovr_flag), .level(level)
);

// File: tb/tb_serial_rx.sv
module tb_serial_rx;
  localparam int DEPTH = 16;
  localparam int TDIV  = 2;
  localparam int BITC  = 16 * TDIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick16 = 1'b0;
  logic rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic [2:0] cfg_par = 3'd0;
  logic cfg_mdrop = 1'b0, cfg_autowake = 1'b0, sleep_req = 1'b0;
  logic rd_en = 1'b0, ovr_clr = 1'b0;
  logic rd_vld, rd_perr, rd_ferr, rd_brk, rd_addr, ovr_flag, brk_evt;
  logic [7:0] rd_data;
  logic [$clog2(DEPTH):0] level;

  int total = 0, bad = 0, brk_cnt = 0, tcnt = 0;
  bit finished = 0;

  serial_rx #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_mdrop(cfg_mdrop),
    .cfg_autowake(cfg_autowake), .sleep_req(sleep_req), .rd_en(rd_en),
    .ovr_clr(ovr_clr), .rd_vld(rd_vld), .rd_data(rd_data), .rd_perr(rd_perr),
    .rd_ferr(rd_ferr), .rd_brk(rd_brk), .rd_addr(rd_addr), .level(level),
    .ovr_flag(ovr_flag), .brk_evt(brk_evt)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tcnt   = tcnt + 1;
    tick16 = (tcnt % TDIV) == 0;
  end

  always @(posedge clk) if (brk_evt === 1'b1) brk_cnt = brk_cnt + 1;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int nbits, input bit has9,
                      input logic nb, input logic stopb);
    drive_bit(1'b0);
    for (int i = 0; i < nbits; i++) drive_bit(d[i]);
    if (has9) drive_bit(nb);
    drive_bit(stopb);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  task automatic pop_chk(input string req, input logic [7:0] d, input logic addr,
                         input logic brk, input logic ferr, input logic perr);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, int'({rd_vld, rd_addr, rd_brk, rd_ferr, rd_perr, rd_data}),
               int'({1'b1, addr, brk, ferr, perr, d}));
  endtask

  task automatic t_reset;
    check("R8 reset level", int'(level), 0);
    check("R9 reset ovr", int'(ovr_flag), 0);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check("R8 pop empty no vld", int'(rd_vld), 0);
  endtask

  task automatic t_formats;
    cfg_len = 2'd3; cfg_par = 3'd0;
    send(8'hA5, 8, 0, 1'b0, 1'b1);
    pop_chk("R1 8N1", 8'hA5, 0, 0, 0, 0);
    cfg_len = 2'd0;
    send(8'hF5, 5, 0, 1'b0, 1'b1);
    pop_chk("R1 5-bit right aligned", 8'h15, 0, 0, 0, 0);
    cfg_len = 2'd2; cfg_par = 3'd1;
    send(8'h3C, 7, 1, 1'b0, 1'b1);
    pop_chk("R3 even ok", 8'h3C, 0, 0, 0, 0);
    cfg_par = 3'd2;
    send(8'h3C, 7, 1, 1'b0, 1'b1);
    pop_chk("R3 odd mismatch", 8'h3C, 0, 0, 0, 1);
    cfg_len = 2'd1; cfg_par = 3'd4;
    send(8'h2A, 6, 1, 1'b0, 1'b1);
    pop_chk("R3 force one mismatch", 8'h2A, 0, 0, 0, 1);
    cfg_par = 3'd3;
    send(8'h2A, 6, 1, 1'b0, 1'b1);
    pop_chk("R3 force zero ok", 8'h2A, 0, 0, 0, 0);
    cfg_len = 2'd3; cfg_par = 3'd0;
  endtask

  task automatic t_false_start;
    rxd = 1'b0;
    repeat (3 * TDIV) @(negedge clk);
    rxd = 1'b1;
    repeat (4 * BITC) @(negedge clk);
    check("R2 false start ignored", int'(level), 0);
    send(8'h5A, 8, 0, 1'b0, 1'b1);
    pop_chk("R2 char after glitch", 8'h5A, 0, 0, 0, 0);
  endtask

  task automatic t_frame_err;
    send(8'hC3, 8, 0, 1'b0, 1'b0);
    pop_chk("R4 stop low", 8'hC3, 0, 0, 1, 0);
  endtask

  task automatic t_break;
    int b0;
    b0 = brk_cnt;
    rxd = 1'b0;
    repeat (30 * BITC) @(negedge clk);
    check("R5 single break entry", int'(level), 1);
    check("R6 break start event", brk_cnt - b0, 1);
    drive_bit(1'b1);
    drive_bit(1'b1);
    check("R6 break end event", brk_cnt - b0, 2);
    pop_chk("R5 break entry", 8'h00, 0, 1, 0, 0);
  endtask

  task automatic t_midbreak;
    int b0;
    b0 = brk_cnt;
    drive_bit(1'b0);
    drive_bit(1'b1); drive_bit(1'b1); drive_bit(1'b1);
    rxd = 1'b0;
    repeat (30 * BITC) @(negedge clk);
    drive_bit(1'b1);
    drive_bit(1'b1);
    check("R7 two entries", int'(level), 2);
    check("R7 events", brk_cnt - b0, 2);
    pop_chk("R7 cut char", 8'h07, 0, 0, 1, 0);
    pop_chk("R7 break after", 8'h00, 0, 1, 0, 0);
  endtask

  task automatic t_multidrop;
    cfg_mdrop = 1'b1; cfg_autowake = 1'b1; cfg_par = 3'd1;
    send(8'h11, 8, 1, 1'b0, 1'b1);
    check("R11 asleep drops data", int'(level), 0);
    send(8'h22, 8, 1, 1'b1, 1'b1);
    check("R11 address wakes", int'(level), 1);
    send(8'h31, 8, 1, 1'b0, 1'b1);
    check("R11 awake keeps data", int'(level), 2);
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    send(8'h44, 8, 1, 1'b0, 1'b1);
    check("R11 back asleep", int'(level), 2);
    pop_chk("R10 address flag", 8'h22, 1, 0, 0, 0);
    pop_chk("R10 data flag no perr", 8'h31, 0, 0, 0, 0);
    cfg_mdrop = 1'b0; cfg_autowake = 1'b0; cfg_par = 3'd0;
  endtask

  task automatic t_overrun;
    for (int i = 0; i <= DEPTH; i++) send(8'h40 + 8'(i), 8, 0, 1'b0, 1'b1);
    check("R9 full level", int'(level), DEPTH);
    check("R9 ovr set", int'(ovr_flag), 1);
    for (int i = 0; i < DEPTH; i++) pop_chk("R8 R9 order kept", 8'h40 + 8'(i), 0, 0, 0, 0);
    check("R9 ovr sticky", int'(ovr_flag), 1);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    check("R9 ovr cleared", int'(ovr_flag), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_formats();
    t_false_start();
    t_frame_err();
    t_break();
    t_midbreak();
    t_multidrop();
    t_overrun();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule